// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block holds the event-status side of a power-management unit. It answers a 64-byte I/O window whose base address and decode enable come from configuration-space inputs. Inside the window it keeps a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running power-management timer. It raises a level-sensitive system control interrupt (SCI) while any supported event is both pending and enabled.

Software finds out why the SCI fired by reading the status register. It acknowledges the event by writing ones to the bits it has handled. Hardware event inputs are single-cycle pulses that set their status bit. The timer advances on a tick-enable input and records an event each time its top bit changes value. Accesses are 32-bit, dword-aligned, with per-byte write enables, and reads are combinational from the address.

Top module: `pmev_sci_top`

## Requirements
- R1: The window hits only while `cfg_win_en` is 1 and `bus_addr[15:6]` equals `cfg_io_base[15:6]`. The base is the configuration value ANDed with 0xFFC0, so bits 31:16 and 5:0 of `cfg_io_base` have no effect. `bus_hit` reports the decode.
- R2: With no hit, `bus_rdata` is 0xFFFFFFFF and a write changes no register.
- R3: The dword at window offset 0 returns status in bits 15:0. The implemented status bits are timer (bit 0), global lock (bit 5), power button (bit 8) and RTC (bit 10), and all other status bits read 0. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: A pulse on `evt_gbl`, `evt_pwrbtn` or `evt_rtc` sets status bit 5, 8 or 10 at the next edge. A set in the same cycle as a clear of that bit wins.
- R5: The enable register is in bits 31:16 of the dword at offset 0. All 16 bits can be written and read back.
- R6: The control register is in bits 15:0 of the dword at offset 4, and bits 31:16 of that dword read 0. Dwords in the window other than offsets 0, 4 and 8 read 0.
- R7: The timer counts the cycles with `tmr_tick` high, wrapping at 2^TMR_W. The dword at offset 8 returns the count zero-extended, and writes there are ignored.
- R8: Status bit 0 is set in the cycle the timer's top bit changes value, in either direction.
- R9: `sci` is 1 exactly when status AND enable is non-zero in bits 0, 5, 8 or 10. Enable bits elsewhere never raise it.
- R10: A write updates only the bytes whose `bus_be` bit is 1. `bus_be[i]` covers data bits 8i+7..8i.
- R11: After reset, status, enable, control and timer are all zero and `sci` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_io_base | input | 32 | Configuration base value, masked to 64-byte alignment |
| cfg_win_en | input | 1 | Window decode enable |
| bus_addr | input | ADDR_W | I/O byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| bus_hit | output | 1 | Address decodes into the enabled window |
| evt_gbl | input | 1 | Global lock event pulse |
| evt_pwrbtn | input | 1 | Power button event pulse |
| evt_rtc | input | 1 | RTC alarm event pulse |
| tmr_tick | input | 1 | Timer advance enable |
| sci | output | 1 | Level system control interrupt |

## Verification
The bench builds the block with TMR_W set to 8, so the top timer bit changes every 128 ticks. Both the rising and the falling top-bit events then happen within a few hundred cycles, as does the wrap back to zero. ADDR_W and WIN_BITS stay at 16 and 6, and the configuration base carries stray bits above bit 15 and below bit 6. This exercises the 0xFFC0 masking and the window boundary on both sides.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
    localparam int STS_TMR = 0;
    localparam int STS_GBL = 5;
    localparam int STS_PWR = 8;
    localparam int STS_RTC = 10;
    localparam logic [15:0] SCI_SRC_MASK =
        16'((1 << STS_TMR) | (1 << STS_GBL) | (1 << STS_PWR) | (1 << STS_RTC));

    typedef struct packed {
        logic [15:0] sts;
        logic [15:0] en;
        logic [15:0] ctl;
    } pm_regs_t;
endpackage

// File: rtl/pmev_decode.sv
module pmev_decode #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6,
    localparam int IDX_W   = WIN_BITS - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       cfg_base,
    input  logic              win_en,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << WIN_BITS;

    logic unused_cfg;
    assign unused_cfg = ^{cfg_base[31:ADDR_W], cfg_base[WIN_BITS-1:0], addr[1:0]};

    assign hit = win_en && ((addr & BASE_MASK) == (cfg_base[ADDR_W-1:0] & BASE_MASK));
    assign idx = addr[WIN_BITS-1:2];
endmodule

// File: rtl/pmev_timer.sv
module pmev_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TMR_W-1:0] cnt_o,
    output logic             flip_o
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        flip_o = 1'b0;
        if (tick) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            flip_o    = tmr_d.cnt[TMR_W-1] ^ tmr_q.cnt[TMR_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign cnt_o = tmr_q.cnt;
endmodule

// File: rtl/pmev_regs.sv
module pmev_regs
    import pmev_pkg::*;
#(
    parameter int TMR_W = 24,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic             evt_gbl,
    input  logic             evt_pwrbtn,
    input  logic             evt_rtc,
    input  logic             tmr_flip,
    input  logic [TMR_W-1:0] tmr_cnt,
    output logic [31:0]      rdata,
    output logic [15:0]      sts_o,
    output logic [15:0]      en_o
);
    localparam logic [IDX_W-1:0] I_EVT = IDX_W'(0);
    localparam logic [IDX_W-1:0] I_CTL = IDX_W'(1);
    localparam logic [IDX_W-1:0] I_TMR = IDX_W'(2);

    pm_regs_t    regs_d, regs_q;
    logic [31:0] bmask;
    logic [15:0] clr_v, set_v;

    for (genvar b = 0; b < 4; b++) begin : g_bmask
        assign bmask[8*b +: 8] = {8{be[b]}};
    end

    always_comb begin
        regs_d = regs_q;
        clr_v  = '0;
        set_v  = '0;
        if (hit && wr) begin
            case (idx)
                I_EVT: begin
                    clr_v     = wdata[15:0] & bmask[15:0];
                    regs_d.en = (regs_q.en & ~bmask[31:16]) | (wdata[31:16] & bmask[31:16]);
                end
                I_CTL: regs_d.ctl = (regs_q.ctl & ~bmask[15:0]) | (wdata[15:0] & bmask[15:0]);
                default: ;
            endcase
        end
        set_v[STS_TMR] = tmr_flip;
        set_v[STS_GBL] = evt_gbl;
        set_v[STS_PWR] = evt_pwrbtn;
        set_v[STS_RTC] = evt_rtc;
        regs_d.sts = ((regs_q.sts & ~clr_v) | set_v) & SCI_SRC_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (!hit) begin
            rdata = '1;
        end else begin
            case (idx)
                I_EVT:   rdata = {regs_q.en, regs_q.sts};
                I_CTL:   rdata = {16'h0000, regs_q.ctl};
                I_TMR:   rdata = 32'(tmr_cnt);
                default: rdata = '0;
            endcase
        end
    end

    assign sts_o = regs_q.sts;
    assign en_o  = regs_q.en;
endmodule

// File: rtl/pmev_sci_top.sv
module pmev_sci_top
    import pmev_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6,
    parameter int TMR_W    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_io_base,
    input  logic              cfg_win_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_hit,
    input  logic              evt_gbl,
    input  logic              evt_pwrbtn,
    input  logic              evt_rtc,
    input  logic              tmr_tick,
    output logic              sci
);
    localparam int IDX_W = WIN_BITS - 2;

    logic [IDX_W-1:0] idx_w;
    logic [TMR_W-1:0] tmr_cnt_w;
    logic             tmr_flip_w;
    logic [15:0]      sts_w, en_w;

    pmev_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .addr(bus_addr), .cfg_base(cfg_io_base), .win_en(cfg_win_en),
        .hit(bus_hit), .idx(idx_w)
    );

    pmev_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tmr_tick),
        .cnt_o(tmr_cnt_w), .flip_o(tmr_flip_w)
    );

    pmev_regs #(.TMR_W(TMR_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hit(bus_hit), .idx(idx_w),
        .wr(bus_wr), .be(bus_be), .wdata(bus_wdata),
        .evt_gbl(evt_gbl), .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc),
        .tmr_flip(tmr_flip_w), .tmr_cnt(tmr_cnt_w),
        .rdata(bus_rdata), .sts_o(sts_w), .en_o(en_w)
    );

    assign sci = |(sts_w & en_w & SCI_SRC_MASK);
endmodule

// File: rtl/pmev_sci_chk.sv
module pmev_sci_chk
    import pmev_pkg::*;
#(
    parameter int WIN_BITS = 6,
    parameter int TMR_W    = 24,
    localparam int IDX_W   = WIN_BITS - 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_hit,
    input logic             bus_wr,
    input logic [3:0]       bus_be,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [IDX_W-1:0] idx,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic [TMR_W-1:0] tmr_cnt,
    input logic             evt_gbl,
    input logic             evt_pwrbtn,
    input logic             evt_rtc,
    input logic             tmr_tick,
    input logic             sci
);
    // R4
    rtc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rtc |=> sts[STS_RTC]);
    // R4
    gbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_gbl |=> sts[STS_GBL]);
    // R3
    pwr_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit && bus_wr && idx == '0 && bus_be[1] && bus_wdata[STS_PWR] && !evt_pwrbtn)
        |=> !sts[STS_PWR]);
    // R8
    tmr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cnt[TMR_W-1] != $past(tmr_cnt[TMR_W-1])) |-> sts[STS_TMR]);
    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_tick |=> $stable(tmr_cnt));
    // R2
    miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_hit) |=> $stable(en));
    // R2
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hit |-> (bus_rdata == 32'hFFFF_FFFF));
    // R9
    sci_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & SCI_SRC_MASK) == 16'h0) |-> !sci);
endmodule

bind pmev_sci_top pmev_sci_chk #(.WIN_BITS(WIN_BITS), .TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_hit(bus_hit), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idx(idx_w), .sts(sts_w), .en(en_w), .tmr_cnt(tmr_cnt_w),
    .evt_gbl(evt_gbl), .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc),
    .tmr_tick(tmr_tick), .sci(sci)
);

// File: tb/pmev_sci_top_tb_top.sv
module pmev_sci_top_tb_top;
    localparam int TW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_io_base = '0;
    logic        cfg_win_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_hit;
    logic        evt_gbl = 1'b0, evt_pwrbtn = 1'b0, evt_rtc = 1'b0, tmr_tick = 1'b0;
    logic        sci;

    int checks = 0;
    int errors = 0;

    logic [15:0]   m_sts = '0, m_en = '0, m_ctl = '0;
    logic [TW-1:0] m_cnt = '0;

    always #4 clk = ~clk;

    pmev_sci_top #(.ADDR_W(16), .WIN_BITS(6), .TMR_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_io_base(cfg_io_base), .cfg_win_en(cfg_win_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_hit(bus_hit), .evt_gbl(evt_gbl),
        .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .tmr_tick(tmr_tick), .sci(sci)
    );

    function automatic logic m_hit(input logic [15:0] a);
        return cfg_win_en && ((a & 16'hFFC0) == (cfg_io_base[15:0] & 16'hFFC0));
    endfunction

    function automatic logic [31:0] m_read(input logic [15:0] a);
        if (!m_hit(a)) return 32'hFFFF_FFFF;
        case (a[5:2])
            4'd0:    return {m_en, m_sts};
            4'd1:    return {16'h0, m_ctl};
            4'd2:    return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_sci();
        return |(m_sts & m_en & 16'h0521);
    endfunction

    task automatic step(input logic wr, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input logic g, input logic p,
                        input logic r, input logic t);
        logic [31:0]   bm;
        logic [15:0]   clr, setv, n_sts, n_en, n_ctl;
        logic [TW-1:0] n_cnt;
        bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
        evt_gbl = g; evt_pwrbtn = p; evt_rtc = r; tmr_tick = t;
        clr = '0; n_en = m_en; n_ctl = m_ctl;
        if (wr && m_hit(a)) begin
            if (a[5:2] == 4'd0) begin
                clr  = wd[15:0] & bm[15:0];
                n_en = (m_en & ~bm[31:16]) | (wd[31:16] & bm[31:16]);
            end else if (a[5:2] == 4'd1) begin
                n_ctl = (m_ctl & ~bm[15:0]) | (wd[15:0] & bm[15:0]);
            end
        end
        n_cnt = t ? m_cnt + 1'b1 : m_cnt;
        setv = '0;
        setv[0] = t && (n_cnt[TW-1] != m_cnt[TW-1]);
        setv[5] = g; setv[8] = p; setv[10] = r;
        n_sts = ((m_sts & ~clr) | setv) & 16'h0521;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; evt_gbl = 1'b0; evt_pwrbtn = 1'b0; evt_rtc = 1'b0; tmr_tick = 1'b0;
        m_sts = n_sts; m_en = n_en; m_ctl = n_ctl; m_cnt = n_cnt;
    endtask

    task automatic check_rd(input logic [15:0] a, input string tag);
        logic [31:0] e;
        bus_addr = a;
        #1;
        e = m_read(a);
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s rdata @%h: actual %h expected %h", tag, a, bus_rdata, e);
        end
        checks++;
        if (bus_hit !== m_hit(a)) begin
            errors++;
            $display("FAIL %s hit @%h: actual %b expected %b", tag, a, bus_hit, m_hit(a));
        end
        checks++;
        if (sci !== m_sci()) begin
            errors++;
            $display("FAIL %s sci: actual %b expected %b", tag, sci, m_sci());
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state, R2 window disabled reads all ones
        check_rd(16'h0000, "R11");
        check_rd(16'h0008, "R2");
        // R2: write while disabled has no effect
        step(1'b1, 16'h0000, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_win_en = 1'b1;
        check_rd(16'h0000, "R2");
        // R1: base masking with stray bits
        cfg_io_base = 32'h1234_AB7F;
        base = 16'hAB40;
        check_rd(base, "R1");
        check_rd(16'hAB80, "R1");
        check_rd(16'hAB3C, "R1");
        check_rd(base + 16'h3C, "R6");
        // R5 enable readback
        step(1'b1, base, 4'b1100, 32'hFADE_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base, "R5");
        // R9: only unsupported enables set, all events pending -> sci low
        step(1'b0, base, 4'h0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
        check_rd(base, "R9");
        step(1'b1, base, 4'b1100, 32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base, "R9");
        // R3: writing zeros leaves status, writing one clears
        step(1'b1, base, 4'b0011, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base, "R3");
        step(1'b1, base, 4'b0011, 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base, "R3");
        // R4: set wins over clear
        step(1'b1, base, 4'b0011, 32'h0000_0420, 1'b1, 1'b0, 1'b0, 1'b0);
        check_rd(base, "R4");
        // R10: byte enables
        step(1'b1, base + 16'h4, 4'b0001, 32'h1234_BEEF, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base + 16'h4, "R10");
        step(1'b1, base, 4'b0100, 32'h00A5_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base, "R10");
        // R7: timer write ignored, counting
        step(1'b1, base + 16'h8, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base + 16'h8, "R7");
        ticks(127);
        check_rd(base + 16'h8, "R7");
        check_rd(base, "R8");
        ticks(1);
        check_rd(base, "R8");
        step(1'b1, base, 4'b1111, 32'h0001_0001, 1'b0, 1'b0, 1'b0, 1'b0);
        check_rd(base, "R9");
        ticks(128);
        check_rd(base + 16'h8, "R7");
        check_rd(base, "R8");
        // random mix, all requirements
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            a = base | 16'(($urandom % 16) << 2) | 16'($urandom % 4);
            if ($urandom % 8 == 0) a = 16'($urandom);
            if ($urandom % 40 == 0) cfg_win_en = ~cfg_win_en;
            step(($urandom % 2) == 1, a, 4'($urandom), $urandom,
                 ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                 ($urandom % 2) == 1);
            check_rd(base | 16'(($urandom % 4) << 2), "R3_R9_rand");
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule